// File: doc/BRIEF.md
# Accumulator Shift-Add Unit with Flags

This block keeps two 56-bit signed accumulators, A and B. Each is split into an 8-bit extension, a 24-bit upper word and a 24-bit lower word. When started, it doubles the chosen destination accumulator by shifting it left one place, with a zero entering at the bottom. It adds the chosen source accumulator to that doubled value and writes the sum back into the destination. Either accumulator can be the source, the destination, or both. This shift-and-add step is the core of restoring-style division and of radix-2 butterfly scaling.

Each operation also refreshes a seven-bit condition-code register. The register holds carry, overflow, zero, negative, unnormalized, extension-in-use and a sticky limit flag. A two-bit scaling-mode input moves the bit window that the extension and unnormalized flags look at. Load ports preset either accumulator, and a write port loads the whole condition-code register.

Top module: `acc_shift_add_unit`

## Requirements
- R1: One clock edge after `start_i`, the destination holds (source + 2 × destination) modulo 2^56. The destination is shifted left one bit with a zero entering bit 0 before the add.
- R2: The selects use 0 for A and 1 for B. Source and destination may be the same accumulator, which gives 3 × its value. The accumulator that is not the destination keeps its value.
- R3: Overflow (ccr bit 1) is set when the signed add of the source and the shifted destination overflows, or when the shift changes bit 55 of the destination (bit 55 ≠ bit 54 before the shift), or both.
- R4: Carry (ccr bit 0) is the carry out of bit 55 of the unsigned 56-bit add of the source and the shifted destination.
- R5: Negative (ccr bit 3) equals bit 55 of the result. Zero (ccr bit 2) is set when all 56 result bits are 0.
- R6: Extension-in-use (ccr bit 5) is set unless the result bits in the mode's window are all equal. The windows are: mode 2'b00 (no scaling) bits 55..47, mode 2'b01 (scale down) bits 55..48, mode 2'b10 (scale up) bits 55..46. Mode 2'b11 behaves as 2'b00.
- R7: Unnormalized (ccr bit 4) is set when a bit pair of the result is equal. The pair is bits 47/46 for mode 2'b00 and 2'b11, bits 48/47 for mode 2'b01, and bits 46/45 for mode 2'b10.
- R8: Limit (ccr bit 6) is ORed with each operation's overflow. Only a condition-code write or reset clears it.
- R9: `ccr_wr_i` loads all seven bits from `ccr_wr_val_i` on the next edge. A write in the same cycle as `start_i` takes precedence over the operation's flags.
- R10: `load_a_i` / `load_b_i` preset the accumulator on the next edge. When a load and an operation target the same accumulator in one cycle, the load wins. An operation always reads the values held before the edge.
- R11: Without `start_i` or `ccr_wr_i`, the condition codes hold their value. Without a start or a load, the accumulators hold their value.
- R12: While reset is applied, both accumulators and the condition-code register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Perform one shift-add operation |
| src_sel_i | input | 1 | Source accumulator (0 = A, 1 = B) |
| dst_sel_i | input | 1 | Destination accumulator (0 = A, 1 = B) |
| scale_mode_i | input | 2 | Scaling mode for the extension and unnormalized flags |
| load_a_i | input | 1 | Preset accumulator A |
| load_a_val_i | input | 56 | Value preset into A |
| load_b_i | input | 1 | Preset accumulator B |
| load_b_val_i | input | 56 | Value preset into B |
| ccr_wr_i | input | 1 | Write the condition-code register |
| ccr_wr_val_i | input | 7 | Value written into the condition-code register |
| acc_a_o | output | 56 | Accumulator A |
| acc_b_o | output | 56 | Accumulator B |
| ccr_o | output | 7 | Condition codes {L,E,U,N,Z,V,C} from bit 6 down to bit 0 |

## Verification
Operands are drawn from four shapes:
- Fully random words, which mostly drive the carry and the upper bits.
- Small sign-extended values, which leave the extension clear and set unnormalized.
- Values next to the sign boundary at bits 55/54, which tell the shift overflow apart from the add overflow.
- Values around bit 47, which tell the three scaling windows apart.

Directed cases cover the known check vector, a source equal to the destination, a result of zero with a carry out, and collisions of a load or a condition-code write with an operation. They also cover the limit flag surviving later clean operations until a write clears it.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [1:0] {
    SCALE_NONE = 2'b00,
    SCALE_DOWN = 2'b01,
    SCALE_UP   = 2'b10,
    SCALE_RSVD = 2'b11
  } scale_mode_e;

  localparam int CC_W     = 7;
  localparam int CC_CARRY = 0;
  localparam int CC_OVF   = 1;
  localparam int CC_ZERO  = 2;
  localparam int CC_NEG   = 3;
  localparam int CC_UNNRM = 4;
  localparam int CC_EXT   = 5;
  localparam int CC_LIMIT = 6;

  localparam int NUM_ACC  = 2;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/acc_shift_adder.sv
module acc_shift_adder #(
  parameter int W = 56
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] dbl;
  logic [W:0]   wide;
  logic         ovf_add;
  logic         ovf_shift;

  always_comb begin
    dbl       = {dst_i[W-2:0], 1'b0};
    wide      = {1'b0, src_i} + {1'b0, dbl};
    sum_o     = wide[W-1:0];
    carry_o   = wide[W];
    ovf_shift = dst_i[W-1] ^ dst_i[W-2];
    ovf_add   = (src_i[W-1] ~^ dbl[W-1]) & (wide[W-1] ^ src_i[W-1]);
    ovf_o     = ovf_add | ovf_shift;
  end
endmodule

// File: rtl/acc_cc_eval.sv
module acc_cc_eval
  import acc_pkg::*;
#(
  parameter int W        = 56,
  parameter int NORM_BIT = 47
) (
  input  logic [W-1:0]  res_i,
  input  scale_mode_e   mode_i,
  output logic          neg_o,
  output logic          zero_o,
  output logic          ext_o,
  output logic          unnrm_o
);
  int   pivot;
  logic diff;

  always_comb begin
    case (mode_i)
      SCALE_DOWN: pivot = NORM_BIT + 1;
      SCALE_UP:   pivot = NORM_BIT - 1;
      default:    pivot = NORM_BIT;
    endcase
    diff = 1'b0;
    for (int i = 0; i < W - 1; i++) begin
      if (i >= pivot) diff = diff | (res_i[i] ^ res_i[W-1]);
    end
    ext_o   = diff;
    unnrm_o = ~(res_i[pivot] ^ res_i[pivot-1]);
    neg_o   = res_i[W-1];
    zero_o  = ~|res_i;
  end
endmodule

// File: rtl/acc_reg_bank.sv
module acc_reg_bank #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en_i,
  input  logic [W-1:0] load_val_i,
  input  logic         upd_en_i,
  input  logic [W-1:0] upd_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = load_en_i | upd_en_i;
    d  = load_en_i ? load_val_i : upd_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/acc_shift_add_unit.sv
module acc_shift_add_unit
  import acc_pkg::*;
#(
  parameter  int EXT_W = 8,
  parameter  int MSP_W = 24,
  parameter  int LSP_W = 24,
  localparam int ACC_W = EXT_W + MSP_W + LSP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             src_sel_i,
  input  logic             dst_sel_i,
  input  logic [1:0]       scale_mode_i,
  input  logic             load_a_i,
  input  logic [ACC_W-1:0] load_a_val_i,
  input  logic             load_b_i,
  input  logic [ACC_W-1:0] load_b_val_i,
  input  logic             ccr_wr_i,
  input  logic [CC_W-1:0]  ccr_wr_val_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic [CC_W-1:0]  ccr_o
);
  localparam int NORM_BIT = MSP_W + LSP_W - 1;

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc_q    [NUM_ACC];
  logic [ACC_W-1:0] load_val [NUM_ACC];
  logic             load_en  [NUM_ACC];
  logic [ACC_W-1:0] src_val;
  logic [ACC_W-1:0] dst_val;
  logic [ACC_W-1:0] sum;
  logic             carry, ovf, neg, zero, ext, unnrm;
  logic [CC_W-1:0]  ccr_q, ccr_d;
  logic             ccr_en;

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    load_en[0]  = load_a_i;
    load_en[1]  = load_b_i;
    load_val[0] = load_a_val_i;
    load_val[1] = load_b_val_i;
    src_val     = acc_q[src_sel_i];
    dst_val     = acc_q[dst_sel_i];
  end

  acc_shift_adder #(.W(ACC_W)) u_adder (
    .src_i(src_val), .dst_i(dst_val),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  acc_cc_eval #(.W(ACC_W), .NORM_BIT(NORM_BIT)) u_cc (
    .res_i(sum), .mode_i(scale_mode_e'(scale_mode_i)),
    .neg_o(neg), .zero_o(zero), .ext_o(ext), .unnrm_o(unnrm)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic upd_en;
    assign upd_en = start_i & (dst_sel_i == 1'(g));
    acc_reg_bank #(.W(ACC_W)) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .load_en_i(load_en[g]), .load_val_i(load_val[g]),
      .upd_en_i(upd_en), .upd_val_i(sum),
      .q_o(acc_q[g])
    );
  end

  always_comb begin
    ccr_en = ccr_wr_i | start_i;
    ccr_d  = ccr_q;
    if (ccr_wr_i) begin
      ccr_d = ccr_wr_val_i;
    end else if (start_i) begin
      ccr_d[CC_CARRY] = carry;
      ccr_d[CC_OVF]   = ovf;
      ccr_d[CC_ZERO]  = zero;
      ccr_d[CC_NEG]   = neg;
      ccr_d[CC_UNNRM] = unnrm;
      ccr_d[CC_EXT]   = ext;
      ccr_d[CC_LIMIT] = ccr_q[CC_LIMIT] | ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ccr_q <= '0;
    else if (ccr_en)  ccr_q <= ccr_d;
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign ccr_o   = ccr_q;
endmodule

// File: rtl/acc_shift_add_sva.sv
module acc_shift_add_sva #(
  parameter int W = 56
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         start_i,
  input logic         src_sel_i,
  input logic         dst_sel_i,
  input logic         load_a_i,
  input logic [W-1:0] load_a_val_i,
  input logic         load_b_i,
  input logic         ccr_wr_i,
  input logic [6:0]   ccr_wr_val_i,
  input logic [W-1:0] acc_a_o,
  input logic [W-1:0] acc_b_o,
  input logic [6:0]   ccr_o
);
  logic [W-1:0] src_v;
  assign src_v = src_sel_i ? acc_b_o : acc_a_o;

  p_sum_a_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i && !dst_sel_i && !load_a_i |=>
      acc_a_o == $past(src_v + {acc_a_o[W-2:0], 1'b0}));

  p_sum_b_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i && dst_sel_i && !load_b_i |=>
      acc_b_o == $past(src_v + {acc_b_o[W-2:0], 1'b0}));

  p_other_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i && !dst_sel_i && !load_b_i |=> acc_b_o == $past(acc_b_o));

  p_ovf_sets_limit_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i && !ccr_wr_i |=> (!ccr_o[1] || ccr_o[6]));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    start_i && !ccr_wr_i && !dst_sel_i && !load_a_i |=>
      ccr_o[2] == (acc_a_o == '0));

  p_limit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    ccr_o[6] && !ccr_wr_i |=> ccr_o[6]);

  p_ccr_write_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    ccr_wr_i |=> ccr_o == $past(ccr_wr_val_i));

  p_load_a_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    load_a_i |=> acc_a_o == $past(load_a_val_i));

  p_ccr_hold_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    !start_i && !ccr_wr_i |=> $stable(ccr_o));

  p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    !start_i && !load_a_i && !load_b_i |=>
      $stable(acc_a_o) && $stable(acc_b_o));

  always @(posedge clk) begin
    if (!rst_ok) begin
      p_reset_zero_r12: assert (acc_a_o == '0 && acc_b_o == '0 && ccr_o == '0);
    end
  end
endmodule

bind acc_shift_add_unit acc_shift_add_sva u_sva (
  .clk(clk), .rst_ok(rst_sync_n), .start_i(start_i),
  .src_sel_i(src_sel_i), .dst_sel_i(dst_sel_i),
  .load_a_i(load_a_i), .load_a_val_i(load_a_val_i), .load_b_i(load_b_i),
  .ccr_wr_i(ccr_wr_i), .ccr_wr_val_i(ccr_wr_val_i),
  .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ccr_o(ccr_o)
);

// File: tb/tb_acc_shift_add_unit.sv
`timescale 1ns/1ps
module tb_acc_shift_add_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, src_sel_i, dst_sel_i;
  logic [1:0]  scale_mode_i;
  logic        load_a_i, load_b_i, ccr_wr_i;
  logic [55:0] load_a_val_i, load_b_val_i;
  logic [6:0]  ccr_wr_val_i;
  logic [55:0] acc_a_o, acc_b_o;
  logic [6:0]  ccr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [55:0] ea, eb;
  logic [6:0]  eccr;

  always #2 clk = ~clk;

  acc_shift_add_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sel_i(src_sel_i),
    .dst_sel_i(dst_sel_i), .scale_mode_i(scale_mode_i),
    .load_a_i(load_a_i), .load_a_val_i(load_a_val_i),
    .load_b_i(load_b_i), .load_b_val_i(load_b_val_i),
    .ccr_wr_i(ccr_wr_i), .ccr_wr_val_i(ccr_wr_val_i),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ccr_o(ccr_o)
  );

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic ext_ref(input logic [55:0] r, input logic [1:0] m);
    case (m)
      2'b01:   return !(r[55:48] == 8'h00 || r[55:48] == 8'hFF);
      2'b10:   return !(r[55:46] == 10'h000 || r[55:46] == 10'h3FF);
      default: return !(r[55:47] == 9'h000 || r[55:47] == 9'h1FF);
    endcase
  endfunction

  function automatic logic unn_ref(input logic [55:0] r, input logic [1:0] m);
    case (m)
      2'b01:   return r[48] == r[47];
      2'b10:   return r[46] == r[45];
      default: return r[47] == r[46];
    endcase
  endfunction

  task automatic compare_all();
    check("R1/R2/R10 acc A", acc_a_o, ea);
    check("R1/R2/R10 acc B", acc_b_o, eb);
    check("R4 carry",        56'(ccr_o[0]), 56'(eccr[0]));
    check("R3 overflow",     56'(ccr_o[1]), 56'(eccr[1]));
    check("R5 zero",         56'(ccr_o[2]), 56'(eccr[2]));
    check("R5 negative",     56'(ccr_o[3]), 56'(eccr[3]));
    check("R7 unnormalized", 56'(ccr_o[4]), 56'(eccr[4]));
    check("R6 extension",    56'(ccr_o[5]), 56'(eccr[5]));
    check("R8 limit",        56'(ccr_o[6]), 56'(eccr[6]));
    check("R9/R11 ccr",      56'(ccr_o),    56'(eccr));
  endtask

  // One cycle: drive at falling edge, update model, compare at next falling edge
  task automatic step(input bit st, input bit s, input bit d, input logic [1:0] m,
                      input bit la, input logic [55:0] va,
                      input bit lb, input logic [55:0] vb,
                      input bit cw, input logic [6:0] cv);
    logic [55:0] sv, dv, sh, res, na, nb;
    logic [56:0] wide;
    logic [6:0]  nc;
    logic        vv;
    start_i = st; src_sel_i = s; dst_sel_i = d; scale_mode_i = m;
    load_a_i = la; load_a_val_i = va; load_b_i = lb; load_b_val_i = vb;
    ccr_wr_i = cw; ccr_wr_val_i = cv;
    na = ea; nb = eb; nc = eccr;
    if (st) begin
      sv   = s ? eb : ea;
      dv   = d ? eb : ea;
      sh   = dv << 1;
      wide = 57'(sv) + 57'(sh);
      res  = wide[55:0];
      vv   = (dv[55] != dv[54]) ||
             ($signed(sv) >= 0 && $signed(sh) >= 0 && $signed(res) < 0) ||
             ($signed(sv) < 0 && $signed(sh) < 0 && $signed(res) >= 0);
      nc   = {eccr[6] | vv, ext_ref(res, m), unn_ref(res, m),
              res[55], res == 56'd0, vv, wide[56]};
      if (d) nb = res; else na = res;
    end
    if (la) na = va;
    if (lb) nb = vb;
    if (cw) nc = cv;
    @(negedge clk);
    ea = na; eb = nb; eccr = nc;
    compare_all();
  endtask

  task automatic idle();
    step(0, 0, 0, 2'b00, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic op(input bit s, input bit d, input logic [1:0] m);
    step(1, s, d, m, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic preset(input logic [55:0] a, input logic [55:0] b);
    step(0, 0, 0, 2'b00, 1, a, 1, b, 0, '0);
  endtask

  function automatic logic [55:0] rand_val();
    logic [55:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 4)
      0: ;
      1: v = 56'($signed(v[23:0]));
      2: v = {v[55], ~v[55] ^ v[0], v[53:0]};
      default: v = 56'($signed(v[48:0]));
    endcase
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start_i = 0; src_sel_i = 0; dst_sel_i = 0; scale_mode_i = 0;
    load_a_i = 0; load_b_i = 0; ccr_wr_i = 0;
    load_a_val_i = '0; load_b_val_i = '0; ccr_wr_val_i = '0;
    ea = '0; eb = '0; eccr = '0;
    repeat (3) @(negedge clk);
    compare_all();                       // R12 reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 check vector, R2 source untouched
    preset(56'h00_000000_000123, 56'h00_005000_000000);
    op(0, 1, 2'b00);
    check("R1 vector B", acc_b_o, 56'h00_00A000_000123);
    check("R2 vector A", acc_a_o, 56'h00_000000_000123);

    // R2 same accumulator as source and destination: 3x
    preset(56'd5, 56'd0);
    op(0, 0, 2'b00);
    check("R2 self 3x", acc_a_o, 56'd15);

    // R3 shift-induced overflow, R8 limit set
    preset(56'h40_000000_000000, 56'd0);
    op(1, 0, 2'b00);
    check("R3 shift overflow", 56'(ccr_o[1]), 56'd1);

    // R4 carry with zero result, R5 zero, R8 limit kept
    preset(56'hFF_FFFFFF_FFFFFF, 56'd2);
    op(1, 0, 2'b00);
    check("R4 carry out", 56'(ccr_o[0]), 56'd1);
    check("R5 zero result", 56'(ccr_o[2]), 56'd1);
    check("R8 limit sticky", 56'(ccr_o[6]), 56'd1);

    // R11 idle holds
    idle();
    idle();

    // R9 write clears limit; write beats a simultaneous operation
    step(0, 0, 0, 2'b00, 0, '0, 0, '0, 1, 7'h00);
    check("R9 limit cleared", 56'(ccr_o[6]), 56'd0);
    preset(56'h40_000000_000000, 56'd0);
    step(1, 1, 0, 2'b00, 0, '0, 0, '0, 1, 7'h15);
    check("R9 write priority", 56'(ccr_o), 56'h15);

    // R6/R7 scaling windows on result 0x00_008000_000000
    for (int m = 0; m < 4; m++) begin
      preset(56'd0, 56'h00_004000_000000);
      op(0, 1, 2'(m));
    end
    preset(56'd0, 56'h00_004000_000000);
    op(0, 1, 2'b10);
    check("R7 unnormalized scale up", 56'(ccr_o[4]), 56'd1);
    preset(56'd0, 56'h00_004000_000000);
    op(0, 1, 2'b01);
    check("R6 extension scale down", 56'(ccr_o[5]), 56'd0);

    // R10 load beats operation on the same accumulator
    preset(56'd7, 56'd9);
    step(1, 0, 1, 2'b00, 0, '0, 1, 56'h12_345678_9ABCDE, 0, '0);
    check("R10 load priority", acc_b_o, 56'h12_345678_9ABCDE);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom % 16);
      step(k < 11, 1'($urandom), 1'($urandom), 2'($urandom),
           k >= 11 || ($urandom % 8 == 0), rand_val(),
           k >= 11 || ($urandom % 8 == 0), rand_val(),
           ($urandom % 20 == 0), 7'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule